// File: doc/BRIEF.md
# Register-Mapped Serial Peripheral Interface Master

This block is a bus-attached SPI master. Software programs a control word, a baud divisor and an optional queueing mode through a small word-wide register bus. It then writes bytes to a data register. Each accepted byte is shifted out MSB first on the serial data output while one byte is shifted in from the serial data input. Received bytes wait in a receive store, and software reads them back through the same data register. The serial clock is derived from the system clock: every half of a bit period lasts BAUD+1 system clocks, so SCK runs at f_clk / (2*(BAUD+1)).

Four clock modes are selected by two control bits: the idle level of SCK, and whether data changes on the leading edge of each bit. A third control bit moves the input sample point from the middle to the end of each output bit. In the default single-word mode, the transmit and receive stores each hold one byte. In queued mode, both become FIFO_DEPTH-deep FIFOs. Status bits report receive-full, receive-empty, transmit-space, busy and a sticky receive overflow. Two level outputs follow programmable FIFO thresholds. Chip select is not part of the block: it is an ordinary general-purpose output driven by software.

Register offsets (word index on `bus_addr`): 0 control, 1 status, 2 status clear (write-only, reads 0), 3 data, 4 baud. Control bits: 0 enable, 1 master-run, 2 SCK idle-high, 3 early-shift (data changes on the leading edge), 4 late-sample, 5 queued mode, 7:6 transmit-level select, 9:8 receive-level select. Status bits: 0 rx-full, 1 tx-space, 2 rx-empty, 6 overflow, 7 busy.

Top module: `spim_top`

## Requirements
- R1: After reset, status reads 0x06 (tx-space and rx-empty set, all else clear), SCK and SDO are low, and both level outputs are low.
- R2: While idle, SCK equals control bit 2. During a transfer, each bit has two halves of BAUD+1 clocks each. SCK is (bit2 XOR bit3) in the first half and the inverse in the second half, so one byte takes 16*(BAUD+1) clocks.
- R3: SDO presents the byte MSB first. Each bit is held stable across both halves of its bit period.
- R4: With control bit 4 clear, SDI is sampled at the last clock of the first half of each bit. With it set, SDI is sampled at the last clock of the second half. The received byte is assembled MSB first.
- R5: A completed byte sets status bit 0 (capacity reached) and clears bit 2. A read of the data register returns the oldest byte and removes it, which clears bit 0 and sets bit 2 again when the store becomes empty.
- R6: A byte that completes while the receive store is full is discarded and sets status bit 6. Bit 6 stays set until a write to the status-clear register has bit 6 set. Writing 0 there has no effect.
- R7: With control bit 5 set, up to FIFO_DEPTH bytes queue for transmit and status bit 1 clears when the queue is full. Further data writes are dropped. Queued bytes are sent back to back and read back in order.
- R8: Clearing control bit 0 aborts any transfer, flushes both stores and returns SCK to idle. Data writes are ignored while bit 0 is clear. With bit 0 set and bit 1 clear, bytes queue but no transfer starts.
- R9: With enable set, the transmit level output follows bits 7:6 (0: queue empty, 1: space free, 2: at most half full, 3: never). The receive level output follows bits 9:8 (0: not empty, 1: at least half full, 2: full, 3: never). Half is FIFO_DEPTH/2 in queued mode and 1 otherwise.
- R10: BAUD = 0 gives a bit period of two system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on bus_rdata one cycle later |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Registered read data |
| spi_sck | output | 1 | Serial clock |
| spi_sdo | output | 1 | Serial data out |
| spi_sdi | input | 1 | Serial data in |
| irq_tx | output | 1 | Transmit level flag |
| irq_rx | output | 1 | Receive level flag |

## Verification
Single transfers are run in all four clock modes and at divisors 0, 1 and 2. The bench checks SCK and SDO on every clock against a waveform computed from elapsed time, which separates errors in polarity, edge choice and half-period length. For the sample-point test, the bench drives SDI with one pattern during first halves and a different pattern during second halves. The received byte then shows directly which edge was sampled. Further sequences cover back-to-back queued bytes on a loopback, with one write past capacity, as well as a second completion into a full store, a mid-transfer disable, and writes made while the block is stopped or not running.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_STAT = 3'd1;
  localparam logic [2:0] REG_CLR  = 3'd2;
  localparam logic [2:0] REG_DATA = 3'd3;
  localparam logic [2:0] REG_BAUD = 3'd4;

  localparam int CTRL_W    = 10;
  localparam int ST_RXFULL = 0;
  localparam int ST_TXSPC  = 1;
  localparam int ST_RXEMP  = 2;
  localparam int ST_OVF    = 6;
  localparam int ST_BUSY   = 7;

  typedef struct packed {
    logic [1:0] rx_lvl;
    logic [1:0] tx_lvl;
    logic       queued;
    logic       late;
    logic       early_shift;
    logic       idle_high;
    logic       run;
    logic       on;
  } ctrl_t;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [CW-1:0] cap,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] cnt
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign do_push = push && (cnt < cap);
  assign do_pop  = pop && (cnt != '0);
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int W  = 8,
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          start,
  input  logic [W-1:0]  tx_byte,
  input  logic          idle_high,
  input  logic          early_shift,
  input  logic          late,
  input  logic [BW-1:0] baud,
  input  logic          sdi,
  output logic          take,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  rx_byte,
  output logic          sck,
  output logic          sdo
);
  localparam int HW = $clog2(2 * W);
  localparam logic [HW-1:0] LAST = HW'(2 * W - 1);

  logic [HW-1:0] half;
  logic [BW-1:0] cnt;
  logic [W-1:0]  sh, rsh;

  assign take = en && !busy && start;
  assign sdo  = sh[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      half    <= '0;
      cnt     <= '0;
      sh      <= '0;
      rsh     <= '0;
      rx_byte <= '0;
      sck     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        busy <= 1'b0;
        half <= '0;
        cnt  <= '0;
        sh   <= '0;
        sck  <= idle_high;
      end else if (!busy) begin
        sck <= idle_high;
        if (start) begin
          busy <= 1'b1;
          sh   <= tx_byte;
          half <= '0;
          cnt  <= '0;
          sck  <= idle_high ^ early_shift;
        end
      end else if (cnt < baud) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        if (!half[0]) begin
          if (!late) rsh <= {rsh[W-2:0], sdi};
          half <= half + 1'b1;
          sck  <= ~(idle_high ^ early_shift);
        end else begin
          if (late) rsh <= {rsh[W-2:0], sdi};
          if (half == LAST) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            rx_byte <= late ? {rsh[W-2:0], sdi} : rsh;
            sh      <= '0;
            half    <= '0;
            sck     <= idle_high;
          end else begin
            half <= half + 1'b1;
            sh   <= {sh[W-2:0], 1'b0};
            sck  <= idle_high ^ early_shift;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int WORD_W     = 8,
  parameter int BAUD_W     = 16,
  parameter int BUS_W      = 32,
  parameter int ADDR_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              spi_sck,
  output logic              spi_sdo,
  input  logic              spi_sdi,
  output logic              irq_tx,
  output logic              irq_rx
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CAP = CNT_W'(FIFO_DEPTH);
  localparam logic [CNT_W-1:0] HALF_CAP = CNT_W'(FIFO_DEPTH / 2);

  ctrl_t             ctrl_q;
  logic [BAUD_W-1:0] baud_q;
  logic              ovf_q;
  logic [CNT_W-1:0]  cap, half_lvl, tx_cnt, rx_cnt;
  logic [WORD_W-1:0] tx_dout, rx_dout, rx_byte;
  logic              ctl_on, ctl_idle_high;
  logic              hit_ctrl, hit_data, hit_clr, hit_baud;
  logic              tx_push, tx_pop, rx_push, rx_pop;
  logic              eng_busy, eng_done;
  logic              rx_full, rx_empty, tx_space, clr_hit;
  logic [BUS_W-1:0]  stat_w;
  logic              unused_bits;

  assign ctl_on        = ctrl_q.on;
  assign ctl_idle_high = ctrl_q.idle_high;
  assign cap           = ctrl_q.queued ? FULL_CAP : CNT_W'(1);
  assign half_lvl      = ctrl_q.queued ? HALF_CAP : CNT_W'(1);
  assign unused_bits   = ^bus_wdata[BUS_W-1:CTRL_W];

  assign hit_ctrl = bus_wr && (bus_addr == REG_CTRL);
  assign hit_data = bus_wr && (bus_addr == REG_DATA);
  assign hit_clr  = bus_wr && (bus_addr == REG_CLR);
  assign hit_baud = bus_wr && (bus_addr == REG_BAUD);
  assign clr_hit  = hit_clr && bus_wdata[ST_OVF];

  assign tx_push  = hit_data && ctl_on;
  assign rx_pop   = bus_rd && (bus_addr == REG_DATA);
  assign rx_full  = (rx_cnt >= cap);
  assign rx_empty = (rx_cnt == '0);
  assign tx_space = (tx_cnt < cap);
  assign rx_push  = eng_done && !rx_full;

  always_comb begin
    stat_w            = '0;
    stat_w[ST_RXFULL] = rx_full;
    stat_w[ST_TXSPC]  = tx_space;
    stat_w[ST_RXEMP]  = rx_empty;
    stat_w[ST_OVF]    = ovf_q;
    stat_w[ST_BUSY]   = eng_busy;
  end

  spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_txq (
    .clk(clk), .rst(rst), .clr(!ctl_on), .cap(cap),
    .push(tx_push), .din(bus_wdata[WORD_W-1:0]),
    .pop(tx_pop), .dout(tx_dout), .cnt(tx_cnt)
  );

  spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_rxq (
    .clk(clk), .rst(rst), .clr(!ctl_on), .cap(cap),
    .push(rx_push), .din(rx_byte),
    .pop(rx_pop), .dout(rx_dout), .cnt(rx_cnt)
  );

  spim_shifter #(.W(WORD_W), .BW(BAUD_W)) u_eng (
    .clk(clk), .rst(rst), .en(ctl_on),
    .start(ctrl_q.run && (tx_cnt != '0)), .tx_byte(tx_dout),
    .idle_high(ctrl_q.idle_high), .early_shift(ctrl_q.early_shift),
    .late(ctrl_q.late), .baud(baud_q), .sdi(spi_sdi),
    .take(tx_pop), .busy(eng_busy), .done(eng_done), .rx_byte(rx_byte),
    .sck(spi_sck), .sdo(spi_sdo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      baud_q    <= '0;
      ovf_q     <= 1'b0;
      bus_rdata <= '0;
      irq_tx    <= 1'b0;
      irq_rx    <= 1'b0;
    end else begin
      if (hit_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (hit_baud) baud_q <= bus_wdata[BAUD_W-1:0];

      if (eng_done && rx_full) ovf_q <= 1'b1;
      else if (clr_hit)        ovf_q <= 1'b0;

      if (bus_rd) begin
        case (bus_addr)
          REG_CTRL: bus_rdata <= BUS_W'(ctrl_q);
          REG_STAT: bus_rdata <= stat_w;
          REG_DATA: bus_rdata <= rx_empty ? '0 : BUS_W'(rx_dout);
          REG_BAUD: bus_rdata <= BUS_W'(baud_q);
          default:  bus_rdata <= '0;
        endcase
      end

      case (ctrl_q.tx_lvl)
        2'd0:    irq_tx <= ctl_on && (tx_cnt == '0);
        2'd1:    irq_tx <= ctl_on && tx_space;
        2'd2:    irq_tx <= ctl_on && (tx_cnt <= half_lvl);
        default: irq_tx <= 1'b0;
      endcase
      case (ctrl_q.rx_lvl)
        2'd0:    irq_rx <= ctl_on && !rx_empty;
        2'd1:    irq_rx <= ctl_on && (rx_cnt >= half_lvl);
        2'd2:    irq_rx <= ctl_on && rx_full;
        default: irq_rx <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          on,
  input logic          idle_high,
  input logic          busy,
  input logic          sck,
  input logic          sdo,
  input logic          done,
  input logic          rx_full,
  input logic          rx_pop,
  input logic [CW-1:0] rx_cnt,
  input logic          ovf,
  input logic          clr_hit
);
  // R2: settled idle keeps SCK at the programmed idle level
  assert_idle_sck_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && $stable(idle_high)) |-> (sck == idle_high));

  // R3: SDO only moves together with an SCK transition or a busy change
  assert_sdo_steady_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && $stable(sck)) |-> $stable(sdo));

  // R6: completion into a full store keeps the count and flags overflow
  assert_ovf_discard_R6: assert property (@(posedge clk) disable iff (rst)
    (done && rx_full && !rx_pop) |=> (rx_cnt == $past(rx_cnt)) && ovf);

  // R6: overflow is sticky until cleared by a one in bit 6
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr_hit) |=> ovf);

  // R8: a disabled block has no transfer in progress
  assert_off_stops_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(on) |-> !busy);
endmodule

bind spim_top spim_checker #(.CW(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .on(ctl_on), .idle_high(ctl_idle_high),
  .busy(eng_busy), .sck(spi_sck), .sdo(spi_sdo), .done(eng_done),
  .rx_full(rx_full), .rx_pop(rx_pop), .rx_cnt(rx_cnt), .ovf(ovf_q),
  .clr_hit(clr_hit)
);

// File: tb/test_spim_top.sv
module test_spim_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sck, sdo, sdi, sdi_drv = 1'b0, loop = 1'b0;
  logic        irq_tx, irq_rx;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  assign sdi = loop ? sdo : sdi_drv;

  always #5 clk = ~clk;

  spim_top i_spim_top (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(sck), .spi_sdo(sdo), .spi_sdi(sdi),
    .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  // Time-based reference: drives SDI per half and compares SCK/SDO each clock.
  task automatic xfer(input logic [7:0] tx, input logic [7:0] pa, input logic [7:0] pb,
                      input int brg, input bit cpol, input bit cpha);
    int bad_sck = 0, bad_sdo = 0;
    wr(3'd3, {24'd0, tx});
    @(posedge clk);
    for (int n = 0; n < 16 * (brg + 1); n++) begin
      int h, b;
      @(negedge clk);
      h = n / (brg + 1);
      b = h / 2;
      sdi_drv = (h % 2 == 0) ? pa[7-b] : pb[7-b];
      if (sck !== (cpol ^ cpha ^ h[0])) bad_sck++;
      if (sdo !== tx[7-b]) bad_sdo++;
      @(posedge clk);
    end
    @(negedge clk);
    chk("R2 sck waveform mismatches", bad_sck, 0);
    chk("R3 sdo bit mismatches", bad_sdo, 0);
    chk("R2 sck back to idle", sck, cpol);
    repeat (2) @(posedge clk);
  endtask

  task automatic run_mode(input bit [1:0] m, input bit late, input int brg,
                          input logic [7:0] tx, input logic [7:0] pa, input logic [7:0] pb);
    logic [31:0] d;
    wr(3'd4, brg);
    wr(3'd0, 32'h3 | (m[1] << 2) | (m[0] << 3) | (late << 4));
    xfer(tx, pa, pb, brg, m[1], m[0]);
    rd(3'd3, d);
    chk(late ? "R4 late sample byte" : "R4 middle sample byte", d, late ? pb : pa);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  expq[$];
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 sck low", sck, 0);
    chk("R1 sdo low", sdo, 0);
    chk("R1 irq_tx low", irq_tx, 0);
    chk("R1 irq_rx low", irq_rx, 0);
    rd(3'd1, d);
    chk("R1 status", d, 32'h06);

    // R5/R9 normal mode transfer, mode 0, middle sample
    wr(3'd4, 2);
    wr(3'd0, 32'h003);
    xfer(8'hA5, 8'h3C, 8'hC3, 2, 0, 0);
    rd(3'd1, d);
    chk("R5 status after byte", d, 32'h03);
    chk("R9 irq_rx not-empty level", irq_rx, 1);
    rd(3'd3, d);
    chk("R4 middle sample mode0", d, 32'h3C);
    @(posedge clk); @(negedge clk);
    chk("R9 irq_rx after read", irq_rx, 0);
    rd(3'd1, d);
    chk("R5 status after read", d, 32'h06);

    // R4/R10 other modes and sample points
    run_mode(2'd3, 1'b1, 0, 8'h5A, 8'h0F, 8'hF0);
    run_mode(2'd1, 1'b0, 1, 8'hC6, 8'h96, 8'h69);
    run_mode(2'd2, 1'b1, 1, 8'h3B, 8'h81, 8'h7E);
    run_mode(2'd0, 1'b1, 0, 8'hE1, 8'h55, 8'hAA);

    // R6 overflow in single-word mode
    wr(3'd4, 1);
    wr(3'd0, 32'h003);
    xfer(8'h11, 8'h22, 8'h22, 1, 0, 0);
    xfer(8'h33, 8'h44, 8'h44, 1, 0, 0);
    rd(3'd1, d);
    chk("R6 overflow flag set", d[6], 1);
    rd(3'd3, d);
    chk("R6 first byte kept", d, 32'h22);
    wr(3'd2, 32'h0);
    rd(3'd1, d);
    chk("R6 zero write keeps flag", d[6], 1);
    wr(3'd2, 32'h40);
    rd(3'd1, d);
    chk("R6 flag cleared", d, 32'h06);

    // R7 queued mode with loopback
    wr(3'd0, 32'h0);
    loop = 1'b1;
    wr(3'd0, 32'h261);
    expq = '{8'h81, 8'h42, 8'h24, 8'h18};
    foreach (expq[i]) wr(3'd3, expq[i]);
    wr(3'd3, 32'h99);
    rd(3'd1, d);
    chk("R7 queue full status", d, 32'h04);
    chk("R9 irq_tx space level", irq_tx, 0);
    wr(3'd0, 32'h263);
    repeat (200) @(posedge clk);
    rd(3'd1, d);
    chk("R7 rx queue full status", d, 32'h03);
    chk("R9 irq_rx full level", irq_rx, 1);
    for (int i = 0; i < 4; i++) begin
      rd(3'd3, d);
      chk("R7 byte order", d, expq[i]);
      if (i == 0) begin
        @(posedge clk); @(negedge clk);
        chk("R9 irq_rx below full", irq_rx, 0);
      end
    end
    rd(3'd1, d);
    chk("R7 fifth write dropped", d, 32'h06);
    loop = 1'b0;

    // R8 abort mid-transfer and writes while stopped
    wr(3'd0, 32'h0);
    wr(3'd4, 20);
    wr(3'd0, 32'h003);
    wr(3'd3, 32'hFF);
    repeat (30) @(posedge clk);
    rd(3'd1, d);
    chk("R8 busy mid transfer", d, 32'h86);
    wr(3'd0, 32'h0);
    repeat (2) @(posedge clk);
    rd(3'd1, d);
    chk("R8 aborted status", d, 32'h06);
    chk("R8 sck idle after abort", sck, 0);
    wr(3'd3, 32'h77);
    wr(3'd0, 32'h003);
    repeat (400) @(posedge clk);
    rd(3'd1, d);
    chk("R8 write while off ignored", d, 32'h06);

    // R8 enabled but not running: byte waits
    wr(3'd0, 32'h001);
    wr(3'd3, 32'h12);
    repeat (50) @(posedge clk);
    rd(3'd1, d);
    chk("R8 held without run", d, 32'h04);
    chk("R8 sck static without run", sck, 0);
    wr(3'd0, 32'h0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule